// File: doc/BRIEF.md
# Exception Entry and Return Unit

This block holds the exception-level control state of a 64-bit processor core and performs the two state changes that move between levels. When the core raises an exception request, the unit works out which level takes it and where the request comes from. It forms the handler address from that level's aligned vector base, and records the faulting PC as the return address. It packs the live processor state into the saved-status word and writes the exception class into the syndrome word. All three records go into the register set of the target level. The same edge moves the live state to the target level, selects the dedicated stack pointer and sets all four interrupt/abort masks.

On a return request, the unit loads the PC from the current level's return-address register and unpacks that level's saved-status word back into the live state. A small register port lets software write and read each level's four registers. The live flags, masks, level and stack select are visible on output ports. A flag port lets the execution datapath update the condition flags.

Top module: `exl_unit`

## Requirements
- R1: The vector base register keeps only bits ADDR_W-1..11. A write clears bits 10..0, and a read always returns zero there.
- R2: One cycle after an entry request, `pc_vld` is 1 and `pc_out` = base + origin*0x200 + type*0x80. The type codes are 0 synchronous, 1 IRQ, 2 FIQ and 3 SError. In any cycle after neither request (or after an ignored return), `pc_vld` is 0.
- R3: Origin codes are 0 = same level on SP0, 1 = same level on dedicated SP, 2 = lower level in 64-bit state, 3 = lower level in 32-bit state (`lower_is_32b`=1). The origin is "lower" exactly when the target level is above the current level; otherwise `cur_spx` picks code 1 or 0.
- R4: A requested level of 0 is raised to 1. A requested level below the current level is taken at the current level, so the level never falls on entry.
- R5: On entry, the target level's return-address register receives `exc_pc`. Its saved-status register receives N,Z,C,V at bits 31..28, D,A,I,F at bits 9..6, the level at bits 3..2 and the stack select at bit 0, with all other bits zero.
- R6: On entry, the target level's syndrome register receives `exc_class` in bits 31..26, with all other bits zero.
- R7: On entry, the live level becomes the target, `cur_spx` becomes 1 and `cur_masks` becomes 4'hF. `cur_flags` is kept.
- R8: One cycle after a return request at a level above 0, `pc_out` is the current level's return address and `pc_vld` is 1. The live state is unpacked from that level's saved-status word, using the bit positions of R5.
- R9: A return request while the live level is 0 has no effect: no `pc_vld`, and level, stack select and masks unchanged.
- R10: When entry and return are requested in the same cycle, only the entry is performed.
- R11: After reset, the level is RESET_LVL (3), `cur_spx`=1, `cur_masks`=4'hF, `cur_flags`=0, `pc_vld`=0 and every register reads zero.
- R12: `flags_we` loads `flags_in` into `cur_flags` at the next edge, except in a cycle that performs an entry or a return, which takes priority.
- R13: With BANKED=1 each level owns its own register set, addressed by `rw_lvl`/`rd_lvl`. Register select codes are 0 vector base, 1 return address, 2 saved status and 3 syndrome. A write to one level leaves other levels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 1 | Exception entry request |
| exc_type | input | 2 | Exception type code |
| exc_lvl | input | 2 | Requested target level |
| exc_class | input | CLASS_W | Exception class for the syndrome |
| exc_pc | input | ADDR_W | PC to return to |
| lower_is_32b | input | 1 | Lower level runs in 32-bit state |
| eret_req | input | 1 | Exception return request |
| flags_we | input | 1 | Condition flag update strobe |
| flags_in | input | 4 | New N,Z,C,V |
| rw_we | input | 1 | Register write strobe |
| rw_sel | input | 2 | Register select for write |
| rw_lvl | input | 2 | Level of the register written |
| rw_wdata | input | ADDR_W | Write data |
| rd_sel | input | 2 | Register select for read |
| rd_lvl | input | 2 | Level of the register read |
| rd_data | output | ADDR_W | Read data, combinational |
| pc_vld | output | 1 | New PC valid strobe |
| pc_out | output | ADDR_W | New PC (handler or return address) |
| cur_lvl | output | 2 | Live exception level |
| cur_spx | output | 1 | Live stack select, 1 = dedicated |
| cur_flags | output | 4 | Live N,Z,C,V |
| cur_masks | output | 4 | Live D,A,I,F masks |

## Verification
The bench builds the unit with its defaults: 64-bit addresses, four levels, a 6-bit class, an 11-bit alignment with 128-byte slots, reset at level 3 and banked register sets. Four banked levels make all four origins reachable, including both lower-level states. They also cover promotion from level 0 and clamping below the current level, and they let a write to one level be checked against another. The full 64-bit base shows that the upper address bits pass through untouched while the low eleven are cleared.

// File: rtl/exl_pkg.sv
package exl_pkg;

   localparam int LVL_W   = 2;
   localparam int CLS_LSB = 26;

   typedef enum logic [1:0] {
      SEL_VBASE = 2'd0,
      SEL_RET   = 2'd1,
      SEL_SAVED = 2'd2,
      SEL_SYND  = 2'd3
   } reg_sel_e;

   typedef enum logic [1:0] {
      ORG_CUR_SP0 = 2'd0,
      ORG_CUR_SPX = 2'd1,
      ORG_LOW_64  = 2'd2,
      ORG_LOW_32  = 2'd3
   } origin_e;

   typedef struct packed {
      logic [3:0]       nzcv;
      logic [3:0]       daif;
      logic [LVL_W-1:0] lvl;
      logic             spx;
   } pstate_t;

   // fixed saved-status layout shared by entry and return
   function automatic logic [31:0] pack_state(input pstate_t s);
      logic [31:0] w;
      w        = '0;
      w[31:28] = s.nzcv;
      w[9:6]   = s.daif;
      w[3:2]   = s.lvl;
      w[0]     = s.spx;
      return w;
   endfunction

   function automatic pstate_t unpack_state(input logic [31:0] w);
      pstate_t s;
      s.nzcv = w[31:28];
      s.daif = w[9:6];
      s.lvl  = w[3:2];
      s.spx  = w[0];
      return s;
   endfunction

endpackage

// File: rtl/exl_vec_sel.sv
module exl_vec_sel
   import exl_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int NUM_LVL    = 4,
   parameter int VEC_ALIGN  = 11,
   parameter int SLOT_SHIFT = 7
) (
   input  logic [LVL_W-1:0]            cur_lvl,
   input  logic                        cur_spx,
   input  logic [LVL_W-1:0]            req_lvl,
   input  logic [1:0]                  req_type,
   input  logic                        lower_is_32b,
   input  logic [ADDR_W-VEC_ALIGN-1:0] vbase_hi,
   output logic [LVL_W-1:0]            tgt_lvl,
   output logic [ADDR_W-1:0]           handler
);

   localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(NUM_LVL - 1);

   logic [LVL_W-1:0] promoted;
   logic [LVL_W-1:0] capped;
   origin_e          origin;

   always_comb begin
      promoted = (req_lvl == '0) ? LVL_W'(1) : req_lvl;
      capped   = (promoted > TOP_LVL) ? TOP_LVL : promoted;
      tgt_lvl  = (capped < cur_lvl) ? cur_lvl : capped;
      if (tgt_lvl > cur_lvl)
         origin = lower_is_32b ? ORG_LOW_32 : ORG_LOW_64;
      else
         origin = cur_spx ? ORG_CUR_SPX : ORG_CUR_SP0;
   end

   // aligned base means the offset is a plain concatenation, no adder
   assign handler = {vbase_hi, origin, req_type, {SLOT_SHIFT{1'b0}}};

endmodule

// File: rtl/exl_bank.sv
module exl_bank
   import exl_pkg::*;
#(
   parameter int ADDR_W    = 64,
   parameter int NUM_LVL   = 4,
   parameter int BANKED    = 1,
   parameter int VEC_ALIGN = 11
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        ent_we,
   input  logic [LVL_W-1:0]            ent_lvl,
   input  logic [ADDR_W-1:0]           ent_ret,
   input  logic [31:0]                 ent_saved,
   input  logic [31:0]                 ent_synd,
   input  logic                        sw_we,
   input  logic [1:0]                  sw_sel,
   input  logic [LVL_W-1:0]            sw_lvl,
   input  logic [ADDR_W-1:0]           sw_data,
   input  logic [1:0]                  rd_sel,
   input  logic [LVL_W-1:0]            rd_lvl,
   output logic [ADDR_W-1:0]           rd_data,
   output logic [ADDR_W-VEC_ALIGN-1:0] tgt_vbase_hi,
   input  logic [LVL_W-1:0]            cur_lvl,
   output logic [ADDR_W-1:0]           cur_ret,
   output pstate_t                     cur_state
);

   localparam int NSETS = (BANKED != 0) ? NUM_LVL : 1;
   localparam int IDX_W = (NSETS > 1) ? $clog2(NSETS) : 1;

   logic [ADDR_W-1:0] vb_a [NSETS];
   logic [ADDR_W-1:0] rt_a [NSETS];
   logic [ADDR_W-1:0] sv_a [NSETS];
   logic [ADDR_W-1:0] sy_a [NSETS];

   function automatic logic [IDX_W-1:0] set_of(input logic [LVL_W-1:0] l);
      if (BANKED == 0 || int'(l) >= NSETS) return '0;
      return IDX_W'(l);
   endfunction

   for (genvar s = 0; s < NSETS; s++) begin : g_set
      logic              ent_hit;
      logic              sw_hit;
      logic [ADDR_W-1:0] vb_q, rt_q, sv_q, sy_q;

      assign ent_hit = ent_we && (set_of(ent_lvl) == IDX_W'(s));
      assign sw_hit  = sw_we  && (set_of(sw_lvl)  == IDX_W'(s));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vb_q <= '0;
            rt_q <= '0;
            sv_q <= '0;
            sy_q <= '0;
         end else begin
            if (sw_hit && sw_sel == SEL_VBASE)
               vb_q <= {sw_data[ADDR_W-1:VEC_ALIGN], {VEC_ALIGN{1'b0}}};
            if (ent_hit) begin
               rt_q <= ent_ret;
               sv_q <= ADDR_W'(ent_saved);
               sy_q <= ADDR_W'(ent_synd);
            end else if (sw_hit) begin
               case (sw_sel)
                  SEL_RET:   rt_q <= sw_data;
                  SEL_SAVED: sv_q <= sw_data;
                  SEL_SYND:  sy_q <= sw_data;
                  default:   ;
               endcase
            end
         end
      end

      assign vb_a[s] = vb_q;
      assign rt_a[s] = rt_q;
      assign sv_a[s] = sv_q;
      assign sy_a[s] = sy_q;
   end

   always_comb begin
      case (rd_sel)
         SEL_VBASE: rd_data = vb_a[set_of(rd_lvl)];
         SEL_RET:   rd_data = rt_a[set_of(rd_lvl)];
         SEL_SAVED: rd_data = sv_a[set_of(rd_lvl)];
         default:   rd_data = sy_a[set_of(rd_lvl)];
      endcase
   end

   assign tgt_vbase_hi = vb_a[set_of(ent_lvl)][ADDR_W-1:VEC_ALIGN];
   assign cur_ret      = rt_a[set_of(cur_lvl)];
   assign cur_state    = unpack_state(sv_a[set_of(cur_lvl)][31:0]);

endmodule

// File: rtl/exl_pstate.sv
module exl_pstate
   import exl_pkg::*;
#(
   parameter int RESET_LVL = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic [LVL_W-1:0] take_lvl,
   input  logic             give_back,
   input  pstate_t          back_state,
   input  logic             flags_we,
   input  logic [3:0]       flags_in,
   output pstate_t          state
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state.nzcv <= 4'h0;
         state.daif <= 4'hF;
         state.lvl  <= LVL_W'(RESET_LVL);
         state.spx  <= 1'b1;
      end else if (take) begin
         state.lvl  <= take_lvl;
         state.spx  <= 1'b1;
         state.daif <= 4'hF;
      end else if (give_back) begin
         state <= back_state;
      end else if (flags_we) begin
         state.nzcv <= flags_in;
      end
   end

endmodule

// File: rtl/exl_unit.sv
module exl_unit
   import exl_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int NUM_LVL    = 4,
   parameter int CLASS_W    = 6,
   parameter int VEC_ALIGN  = 11,
   parameter int SLOT_SHIFT = 7,
   parameter int RESET_LVL  = 3,
   parameter int BANKED     = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               exc_req,
   input  logic [1:0]         exc_type,
   input  logic [1:0]         exc_lvl,
   input  logic [CLASS_W-1:0] exc_class,
   input  logic [ADDR_W-1:0]  exc_pc,
   input  logic               lower_is_32b,
   input  logic               eret_req,
   input  logic               flags_we,
   input  logic [3:0]         flags_in,
   input  logic               rw_we,
   input  logic [1:0]         rw_sel,
   input  logic [1:0]         rw_lvl,
   input  logic [ADDR_W-1:0]  rw_wdata,
   input  logic [1:0]         rd_sel,
   input  logic [1:0]         rd_lvl,
   output logic [ADDR_W-1:0]  rd_data,
   output logic               pc_vld,
   output logic [ADDR_W-1:0]  pc_out,
   output logic [1:0]         cur_lvl,
   output logic               cur_spx,
   output logic [3:0]         cur_flags,
   output logic [3:0]         cur_masks
);

   if (VEC_ALIGN != SLOT_SHIFT + 4) begin : g_bad_align
      $error("exl_unit: VEC_ALIGN must equal SLOT_SHIFT + 4");
   end
   if (NUM_LVL < 2 || NUM_LVL > 4) begin : g_bad_lvls
      $error("exl_unit: NUM_LVL must be 2..4");
   end
   if (RESET_LVL >= NUM_LVL) begin : g_bad_reset
      $error("exl_unit: RESET_LVL out of range");
   end
   if (CLASS_W + CLS_LSB > 32) begin : g_bad_class
      $error("exl_unit: CLASS_W does not fit the syndrome word");
   end
   if (ADDR_W < 32 || ADDR_W <= VEC_ALIGN) begin : g_bad_addr
      $error("exl_unit: ADDR_W too small");
   end

   pstate_t                     ps;
   pstate_t                     ret_state;
   logic [LVL_W-1:0]            tgt_lvl;
   logic [ADDR_W-1:0]           handler;
   logic [ADDR_W-VEC_ALIGN-1:0] tgt_vbase_hi;
   logic [ADDR_W-1:0]           ret_pc;
   logic [31:0]                 synd_word;
   logic                        ret_ok;

   // entry wins over return; a return at the lowest level does nothing
   assign ret_ok    = eret_req && !exc_req && (ps.lvl != '0);
   assign synd_word = 32'(exc_class) << CLS_LSB;

   exl_vec_sel #(
      .ADDR_W     (ADDR_W),
      .NUM_LVL    (NUM_LVL),
      .VEC_ALIGN  (VEC_ALIGN),
      .SLOT_SHIFT (SLOT_SHIFT)
   ) u_sel (
      .cur_lvl      (ps.lvl),
      .cur_spx      (ps.spx),
      .req_lvl      (exc_lvl),
      .req_type     (exc_type),
      .lower_is_32b (lower_is_32b),
      .vbase_hi     (tgt_vbase_hi),
      .tgt_lvl      (tgt_lvl),
      .handler      (handler)
   );

   exl_bank #(
      .ADDR_W    (ADDR_W),
      .NUM_LVL   (NUM_LVL),
      .BANKED    (BANKED),
      .VEC_ALIGN (VEC_ALIGN)
   ) u_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .ent_we       (exc_req),
      .ent_lvl      (tgt_lvl),
      .ent_ret      (exc_pc),
      .ent_saved    (pack_state(ps)),
      .ent_synd     (synd_word),
      .sw_we        (rw_we),
      .sw_sel       (rw_sel),
      .sw_lvl       (rw_lvl),
      .sw_data      (rw_wdata),
      .rd_sel       (rd_sel),
      .rd_lvl       (rd_lvl),
      .rd_data      (rd_data),
      .tgt_vbase_hi (tgt_vbase_hi),
      .cur_lvl      (ps.lvl),
      .cur_ret      (ret_pc),
      .cur_state    (ret_state)
   );

   exl_pstate #(
      .RESET_LVL (RESET_LVL)
   ) u_ps (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (exc_req),
      .take_lvl   (tgt_lvl),
      .give_back  (ret_ok),
      .back_state (ret_state),
      .flags_we   (flags_we),
      .flags_in   (flags_in),
      .state      (ps)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_vld <= 1'b0;
         pc_out <= '0;
      end else if (exc_req) begin
         pc_vld <= 1'b1;
         pc_out <= handler;
      end else if (ret_ok) begin
         pc_vld <= 1'b1;
         pc_out <= ret_pc;
      end else begin
         pc_vld <= 1'b0;
      end
   end

   assign cur_lvl   = ps.lvl;
   assign cur_spx   = ps.spx;
   assign cur_flags = ps.nzcv;
   assign cur_masks = ps.daif;

endmodule

// File: rtl/exl_unit_chk.sv
module exl_unit_chk #(
   parameter int ADDR_W     = 64,
   parameter int VEC_ALIGN  = 11,
   parameter int SLOT_SHIFT = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              exc_req,
   input logic [1:0]        exc_type,
   input logic              eret_req,
   input logic [1:0]        rd_sel,
   input logic [ADDR_W-1:0] rd_data,
   input logic              pc_vld,
   input logic [ADDR_W-1:0] pc_out,
   input logic [1:0]        cur_lvl,
   input logic              cur_spx,
   input logic [3:0]        cur_flags,
   input logic [3:0]        cur_masks
);

   assert_vbase_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel == 2'd0) |-> (rd_data[VEC_ALIGN-1:0] == '0));

   assert_slot_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |=> (pc_vld && pc_out[SLOT_SHIFT-1:0] == '0
                   && pc_out[SLOT_SHIFT+1:SLOT_SHIFT] == $past(exc_type)));

   assert_no_spurious_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!exc_req && !eret_req) |=> !pc_vld);

   assert_level_never_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |=> (cur_lvl >= $past(cur_lvl) && cur_lvl != 2'd0));

   assert_entry_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |=> (cur_masks == 4'hF && cur_spx && cur_flags == $past(cur_flags)));

   assert_low_return_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (eret_req && !exc_req && cur_lvl == 2'd0) |=>
         (!pc_vld && cur_lvl == 2'd0 && $stable(cur_masks) && $stable(cur_spx)));

endmodule

bind exl_unit exl_unit_chk #(
   .ADDR_W     (ADDR_W),
   .VEC_ALIGN  (VEC_ALIGN),
   .SLOT_SHIFT (SLOT_SHIFT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .exc_req   (exc_req),
   .exc_type  (exc_type),
   .eret_req  (eret_req),
   .rd_sel    (rd_sel),
   .rd_data   (rd_data),
   .pc_vld    (pc_vld),
   .pc_out    (pc_out),
   .cur_lvl   (cur_lvl),
   .cur_spx   (cur_spx),
   .cur_flags (cur_flags),
   .cur_masks (cur_masks)
);

// File: tb/sim_exl_unit.sv
`timescale 1ns/1ps
module sim_exl_unit;

   localparam logic [1:0] S_VB = 2'd0, S_RT = 2'd1, S_SV = 2'd2, S_SY = 2'd3;
   localparam logic [63:0] VB1 = 64'h0000_0000_8000_0000;
   localparam logic [63:0] VB2 = 64'h4000_1234_5678_9800;
   localparam logic [63:0] VB3 = 64'h0000_0000_00A0_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exc_req = 1'b0;
   logic [1:0]  exc_type = '0;
   logic [1:0]  exc_lvl = '0;
   logic [5:0]  exc_class = '0;
   logic [63:0] exc_pc = '0;
   logic        lower_is_32b = 1'b0;
   logic        eret_req = 1'b0;
   logic        flags_we = 1'b0;
   logic [3:0]  flags_in = '0;
   logic        rw_we = 1'b0;
   logic [1:0]  rw_sel = '0;
   logic [1:0]  rw_lvl = '0;
   logic [63:0] rw_wdata = '0;
   logic [1:0]  rd_sel = '0;
   logic [1:0]  rd_lvl = '0;
   logic [63:0] rd_data;
   logic        pc_vld;
   logic [63:0] pc_out;
   logic [1:0]  cur_lvl;
   logic        cur_spx;
   logic [3:0]  cur_flags;
   logic [3:0]  cur_masks;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   exl_unit u0 (
      .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_type(exc_type),
      .exc_lvl(exc_lvl), .exc_class(exc_class), .exc_pc(exc_pc),
      .lower_is_32b(lower_is_32b), .eret_req(eret_req), .flags_we(flags_we),
      .flags_in(flags_in), .rw_we(rw_we), .rw_sel(rw_sel), .rw_lvl(rw_lvl),
      .rw_wdata(rw_wdata), .rd_sel(rd_sel), .rd_lvl(rd_lvl), .rd_data(rd_data),
      .pc_vld(pc_vld), .pc_out(pc_out), .cur_lvl(cur_lvl), .cur_spx(cur_spx),
      .cur_flags(cur_flags), .cur_masks(cur_masks)
   );

   function automatic logic [63:0] pk(input logic [3:0] f, input logic [3:0] m,
                                      input logic [1:0] l, input logic s);
      return (64'(f) << 28) | (64'(m) << 6) | (64'(l) << 2) | 64'(s);
   endfunction

   function automatic logic [63:0] hnd(input logic [63:0] b, input int org, input int typ);
      return {b[63:11], 11'b0} + 64'(org * 'h200) + 64'(typ * 'h80);
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] sel, input logic [1:0] lvl, input logic [63:0] d);
      rw_we = 1'b1; rw_sel = sel; rw_lvl = lvl; rw_wdata = d;
      step();
      rw_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] sel, input logic [1:0] lvl, output logic [63:0] d);
      rd_sel = sel; rd_lvl = lvl;
      #1;
      d = rd_data;
   endtask

   task automatic take(input logic [1:0] t, input logic [1:0] l, input logic [5:0] c,
                       input logic [63:0] pc, input logic l32);
      exc_type = t; exc_lvl = l; exc_class = c; exc_pc = pc; lower_is_32b = l32;
      exc_req = 1'b1;
      step();
      exc_req = 1'b0;
   endtask

   task automatic do_eret();
      eret_req = 1'b1;
      step();
      eret_req = 1'b0;
   endtask

   task automatic t_reset();
      logic [63:0] d;
      check("R11 level", 64'(cur_lvl), 64'd3);
      check("R11 spx", 64'(cur_spx), 64'd1);
      check("R11 masks", 64'(cur_masks), 64'hF);
      check("R11 flags", 64'(cur_flags), 64'h0);
      check("R11 pc_vld", 64'(pc_vld), 64'h0);
      rd(S_VB, 2'd3, d); check("R11 vbase3", d, 64'h0);
      rd(S_SV, 2'd1, d); check("R11 saved1", d, 64'h0);
   endtask

   task automatic t_align_bank();
      logic [63:0] d;
      wr(S_VB, 2'd1, 64'h0000_0000_8000_07FF);
      rd(S_VB, 2'd1, d); check("R1 low bits cleared", d, VB1);
      wr(S_VB, 2'd2, 64'h4000_1234_5678_9ABC);
      rd(S_VB, 2'd2, d); check("R1 upper bits kept", d, VB2);
      wr(S_VB, 2'd3, VB3);
      rd(S_VB, 2'd1, d); check("R13 level1 untouched", d, VB1);
      wr(S_RT, 2'd1, 64'h1111);
      rd(S_RT, 2'd2, d); check("R13 level2 ret untouched", d, 64'h0);
      rd(S_RT, 2'd1, d); check("R13 level1 ret", d, 64'h1111);
   endtask

   task automatic t_flags();
      flags_we = 1'b1; flags_in = 4'hA;
      step();
      flags_we = 1'b0;
      check("R12 flag load", 64'(cur_flags), 64'hA);
   endtask

   task automatic t_entry_same();
      logic [63:0] d;
      take(2'd1, 2'd3, 6'h15, 64'h1000, 1'b0);
      check("R2 pc_vld", 64'(pc_vld), 64'd1);
      check("R3 same level SPx handler", pc_out, hnd(VB3, 1, 1));
      check("R7 level", 64'(cur_lvl), 64'd3);
      check("R7 masks", 64'(cur_masks), 64'hF);
      check("R7 flags kept", 64'(cur_flags), 64'hA);
      rd(S_RT, 2'd3, d); check("R5 return addr", d, 64'h1000);
      rd(S_SV, 2'd3, d); check("R5 saved status", d, pk(4'hA, 4'hF, 2'd3, 1'b1));
      rd(S_SY, 2'd3, d); check("R6 syndrome", d, 64'h5400_0000);
      step();
      check("R2 pc_vld pulse ends", 64'(pc_vld), 64'd0);
   endtask

   task automatic t_eret();
      wr(S_SV, 2'd3, pk(4'h4, 4'h0, 2'd1, 1'b0));
      wr(S_RT, 2'd3, 64'h2000);
      do_eret();
      check("R8 pc_vld", 64'(pc_vld), 64'd1);
      check("R8 pc", pc_out, 64'h2000);
      check("R8 level", 64'(cur_lvl), 64'd1);
      check("R8 spx", 64'(cur_spx), 64'd0);
      check("R8 masks", 64'(cur_masks), 64'h0);
      check("R8 flags", 64'(cur_flags), 64'h4);
   endtask

   task automatic t_lower();
      logic [63:0] d;
      take(2'd2, 2'd2, 6'h3C, 64'h3000, 1'b0);
      check("R3 lower 64-bit handler", pc_out, hnd(VB2, 2, 2));
      check("R7 level 2", 64'(cur_lvl), 64'd2);
      rd(S_SV, 2'd2, d); check("R5 saved from level1", d, pk(4'h4, 4'h0, 2'd1, 1'b0));
      rd(S_SY, 2'd2, d); check("R6 syndrome 3C", d, 64'hF000_0000);
      do_eret();
      check("R8 back to level1", 64'(cur_lvl), 64'd1);
      check("R8 pc 3000", pc_out, 64'h3000);
      take(2'd3, 2'd3, 6'h01, 64'h4000, 1'b1);
      check("R3 lower 32-bit handler", pc_out, hnd(VB3, 3, 3));
   endtask

   task automatic t_promote_clamp();
      logic [63:0] d;
      wr(S_SV, 2'd3, pk(4'h0, 4'h0, 2'd1, 1'b0));
      do_eret();
      take(2'd0, 2'd0, 6'h07, 64'h5000, 1'b0);
      check("R4 level0 promoted", 64'(cur_lvl), 64'd1);
      check("R3 same level SP0 handler", pc_out, hnd(VB1, 0, 0));
      rd(S_RT, 2'd1, d); check("R4 level1 ret", d, 64'h5000);
      take(2'd0, 2'd2, 6'h11, 64'h6000, 1'b0);
      check("R3 lower from level1", pc_out, hnd(VB2, 2, 0));
      take(2'd1, 2'd1, 6'h12, 64'h6100, 1'b0);
      check("R4 below current kept", 64'(cur_lvl), 64'd2);
      check("R4 clamped handler", pc_out, hnd(VB2, 1, 1));
      rd(S_RT, 2'd2, d); check("R4 level2 ret", d, 64'h6100);
   endtask

   task automatic t_priority();
      logic [63:0] d;
      logic [3:0]  f0;
      f0 = cur_flags;
      exc_type = 2'd0; exc_lvl = 2'd3; exc_class = 6'h02; exc_pc = 64'h7000;
      lower_is_32b = 1'b0;
      exc_req = 1'b1; eret_req = 1'b1; flags_we = 1'b1; flags_in = ~f0;
      step();
      exc_req = 1'b0; eret_req = 1'b0; flags_we = 1'b0;
      check("R10 entry wins pc", pc_out, hnd(VB3, 2, 0));
      check("R10 entry wins level", 64'(cur_lvl), 64'd3);
      check("R12 flag write lost to entry", 64'(cur_flags), 64'(f0));
      rd(S_RT, 2'd3, d); check("R10 ret3", d, 64'h7000);
   endtask

   task automatic t_eret_low();
      wr(S_SV, 2'd3, 64'h0);
      do_eret();
      check("R8 to level0", 64'(cur_lvl), 64'd0);
      check("R8 pc 7000", pc_out, 64'h7000);
      do_eret();
      check("R9 no pc_vld", 64'(pc_vld), 64'd0);
      check("R9 level stays", 64'(cur_lvl), 64'd0);
      check("R9 masks stay", 64'(cur_masks), 64'h0);
      check("R9 spx stays", 64'(cur_spx), 64'd0);
   endtask

   initial begin
      #(20 * 100000);
      fails++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_align_bank();
      t_flags();
      t_entry_same();
      t_eret();
      t_lower();
      t_promote_clamp();
      t_priority();
      t_eret_low();
      step();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule